// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds a four-bit addend into a four-bit accumulator, one bit position per clock. Each clock, a single full adder combines the lowest bit of the accumulator, the lowest bit of the addend and a stored carry. The sum bit enters the top of the accumulator as the accumulator shifts right. The addend register rotates in step with it. The carry-out of each step is kept in a flip-flop and becomes the carry-in of the next step. After four shift clocks, the accumulator holds the sum and the carry flip-flop holds the carry out of the top bit.

A four-state controller sequences the operation. While the controller is idle, a load pulse writes both registers in parallel and clears the carry. A start pulse then launches exactly four shift cycles. The busy output is high during each of those four cycles. Because the addend rotates back to its original value, the caller can hold start high to add the same addend again. The second addition uses the stored carry as its first carry-in.

Top module: `ser_add_acc`

## Requirements
- R1: After synchronous reset, the accumulator, the addend register and the carry are all 0, and busy is 0.
- R2: When load is 1 while idle, the accumulator takes load_acc, the addend register takes load_addend and the carry becomes 0, all at the next clock edge.
- R3: When start is 1 and load is 0 while idle, the block performs exactly four shift cycles. Busy is 1 in each of those cycles, and the controller then returns to idle.
- R4: On every shift cycle, the accumulator shifts right by one place. The full adder's sum bit enters bit 3, and the carry flip-flop captures the full adder's carry-out.
- R5: When an operation ends, the accumulator equals (A + B + c0) mod 16 and the carry output equals bit 4 of that sum. Here A is the starting accumulator, B is the addend and c0 is the stored carry. For example, 0101 plus 0111 with c0 = 0 gives 1100 with carry 0.
- R6: The addend register rotates right on each shift, so it holds its original value when the operation ends.
- R7: Load and start have no effect while busy.
- R8: When no shift or load takes place, the accumulator, the addend and the carry hold their values.
- R9: If start is still 1 when the block returns to idle, a new addition begins at that edge. The new addition uses the current accumulator, the same addend and the stored carry as its first carry-in.
- R10: When load and start are both 1 while idle, the load takes effect and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load of both registers (acted on only when idle) |
| load_acc | input | 4 | Value loaded into the accumulator |
| load_addend | input | 4 | Value loaded into the addend register |
| start | input | 1 | Begins a four-cycle addition when idle |
| acc | output | 4 | Accumulator contents |
| carry_out | output | 1 | Stored carry (the final carry after completion) |
| busy | output | 1 | High in each shift cycle |

## Verification
The hardest state to reach from the ports is a chained addition. In that case, start is held across the return to idle, so a second addition begins with a non-zero stored carry that no load has cleared. The stimulus loads operand pairs whose sum overflows, holds start high for eight clocks, and checks the result at both completion points. Load pulses are also injected during the middle of an operation to show that the result is not disturbed. Load and start are also raised in the same idle cycle to show that load takes priority.

// File: rtl/ser_add_pkg.sv
package ser_add_pkg;
    localparam int unsigned WIDTH = 4;
    localparam int unsigned STEPS = WIDTH;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_B1   = 2'd1,
        ST_B2   = 2'd2,
        ST_B3   = 2'd3
    } ctrl_state_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic c);
        fa_out_t r;
        r.sum  = a ^ b ^ c;
        r.cout = (a & b) | (a & c) | (b & c);
        return r;
    endfunction
endpackage

// File: rtl/ser_add_fa.sv
module ser_add_fa
    import ser_add_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    output fa_out_t res
);
    always_comb res = full_add(a, b, cin);
endmodule

// File: rtl/ser_add_shreg.sv
module ser_add_shreg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {ser_in, q[W-1:1]};
    end
endmodule

// File: rtl/ser_add_ctrl.sv
module ser_add_ctrl
    import ser_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic load,
    output logic shift,
    output logic load_ok
);
    ctrl_state_e state_q, state_d;

    always_comb begin
        load_ok = load && (state_q == ST_IDLE);
        shift   = (state_q != ST_IDLE) || (start && !load);
        unique case (state_q)
            ST_IDLE: state_d = shift ? ST_B1 : ST_IDLE;
            ST_B1:   state_d = ST_B2;
            ST_B2:   state_d = ST_B3;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_START_BEGINS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && !load) |=> (state_q == ST_B1)); // R3
    AST_LAST_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_B3) |=> (state_q == ST_IDLE)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && load) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/ser_add_acc.sv
module ser_add_acc
    import ser_add_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_acc,
    input  logic [WIDTH-1:0] load_addend,
    input  logic             start,
    output logic [WIDTH-1:0] acc,
    output logic             carry_out,
    output logic             busy
);
    logic             shift, load_ok;
    logic [WIDTH-1:0] acc_q, add_q;
    logic             carry_q;
    fa_out_t          fa;

    ser_add_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .load(load),
        .shift(shift), .load_ok(load_ok)
    );

    ser_add_fa u_fa (
        .a(acc_q[0]), .b(add_q[0]), .cin(carry_q), .res(fa)
    );

    ser_add_shreg #(.W(WIDTH)) u_acc (
        .clk(clk), .rst(rst), .load(load_ok), .load_val(load_acc),
        .shift(shift), .ser_in(fa.sum), .q(acc_q)
    );

    ser_add_shreg #(.W(WIDTH)) u_add (
        .clk(clk), .rst(rst), .load(load_ok), .load_val(load_addend),
        .shift(shift), .ser_in(add_q[0]), .q(add_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          carry_q <= 1'b0;
        else if (load_ok) carry_q <= 1'b0;
        else if (shift)   carry_q <= fa.cout;
    end

    assign acc       = acc_q;
    assign carry_out = carry_q;
    assign busy      = shift;

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        shift |=> (acc_q[WIDTH-2:0] == $past(acc_q[WIDTH-1:1]))); // R4
    AST_ADDEND_ROTATE: assert property (@(posedge clk) disable iff (rst)
        shift |=> (add_q == {$past(add_q[0]), $past(add_q[WIDTH-1:1])})); // R6
    AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> (carry_q == 1'b0)); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift && !load_ok) |=> ($stable(acc_q) && $stable(add_q) && $stable(carry_q))); // R8
endmodule

// File: tb/test_ser_add_acc.sv
module test_ser_add_acc;
    logic       clk = 1'b0;
    logic       rst, load, start;
    logic [3:0] load_acc, load_addend;
    logic [3:0] acc;
    logic       carry_out, busy;
    int         checks = 0;
    int         fails  = 0;

    always #4 clk = ~clk;

    ser_add_acc i_ser_add_acc (
        .clk(clk), .rst(rst), .load(load), .load_acc(load_acc),
        .load_addend(load_addend), .start(start),
        .acc(acc), .carry_out(carry_out), .busy(busy)
    );

    function automatic logic [4:0] ref_sum(input logic [3:0] a, input logic [3:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {4'd0, c};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        load = 1'b1; load_acc = a; load_addend = b;
        @(negedge clk);
        load = 1'b0;
        chk("R2 acc loaded", acc, a);
        chk("R2 carry cleared", carry_out, 0);
    endtask

    // Launches one addition and returns at the negedge after completion.
    task automatic run_add(input logic [3:0] a, input logic [3:0] b, input logic c,
                           input bit poke_load);
        logic [4:0] s;
        s = ref_sum(a, b, c);
        @(negedge clk);
        start = 1'b1;
        #1 chk("R3 busy on start", busy, 1);
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy step1", busy, 1);
        chk("R4 sum bit into msb", acc, {s[0] ^ 1'b0, a[3:1]});
        if (poke_load) begin
            load = 1'b1; load_acc = ~a; load_addend = ~b; start = 1'b1;
        end
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        chk("R3 busy step2", busy, 1);
        @(negedge clk);
        chk("R3 busy step3", busy, 1);
        @(negedge clk);
        chk("R3 idle after four", busy, 0);
        chk(poke_load ? "R7 result sum" : "R5 result sum", acc, s[3:0]);
        chk("R5 final carry", carry_out, s[4]);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [4:0] s1, s2;
        seed = $urandom(32'd2024);
        rst = 1'b1; load = 1'b0; start = 1'b0; load_acc = '0; load_addend = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 acc reset", acc, 0);
        chk("R1 carry reset", carry_out, 0);
        chk("R1 busy reset", busy, 0);

        // Worked case
        do_load(4'b0101, 4'b0111);
        run_add(4'b0101, 4'b0111, 1'b0, 1'b0);
        chk("R5 worked case", acc, 4'b1100);

        // R6: addend preserved, visible by adding it to zero accumulator afterwards
        do_load(4'd0, 4'd9);
        run_add(4'd0, 4'd9, 1'b0, 1'b0);
        run_add(4'd9, 4'd9, 1'b0, 1'b0);
        chk("R6 addend kept (9+9)", acc, 4'd2);

        // R8: hold while idle
        repeat (3) @(negedge clk);
        chk("R8 acc held", acc, 2);
        chk("R8 carry held", carry_out, 1);

        // R7: load and start while busy ignored
        do_load(4'd6, 4'd5);
        run_add(4'd6, 4'd5, 1'b0, 1'b1);

        // R10: load wins over start
        @(negedge clk);
        load = 1'b1; start = 1'b1; load_acc = 4'd13; load_addend = 4'd11;
        #1 chk("R10 busy low with load", busy, 0);
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        chk("R10 acc loaded unshifted", acc, 13);
        @(negedge clk);
        chk("R10 no shift", acc, 13);

        // R9: start held across completion, overflowing sum
        s1 = ref_sum(4'd13, 4'd11, 1'b0);
        s2 = ref_sum(s1[3:0], 4'd11, s1[4]);
        @(negedge clk);
        start = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 first result", acc, s1[3:0]);
        chk("R9 first carry", carry_out, s1[4]);
        chk("R9 busy continues", busy, 1);
        repeat (4) @(negedge clk);
        start = 1'b0;
        chk("R9 chained result", acc, s2[3:0]);
        chk("R9 chained carry", carry_out, s2[4]);
        @(negedge clk);
        chk("R9 idle after chain", busy, 0);

        // Random operands
        for (int i = 0; i < 40; i++) begin
            logic [3:0] a, b;
            a = 4'($urandom_range(15, 0));
            b = 4'($urandom_range(15, 0));
            do_load(a, b);
            run_add(a, b, 1'b0, (i % 5) == 0);
        end

        // R1: reset during an operation
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after mid reset", busy, 0);
        chk("R1 acc after mid reset", acc, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule